// File: doc/BRIEF.md
# Page Access Rights Checker

This block decides whether a memory access to an already translated page may proceed. It takes the final (leaf) translation entry, the kind of access (data read, data write or instruction fetch), the privilege mode of the requester and a flag from the walker that marks a reserved-bit violation. It checks the entry's present bit, its write and user grants and its no-execute bit. It also holds a 32-bit protection-key rights register with sixteen two-bit key slots. The 4-bit key stored in the entry selects one slot, and that slot can block data access to user pages.

A check is presented for one cycle on `chk_valid`. One cycle later the block drives registered results: a valid strobe, either `allow` or `fault`, and, when the access is denied, a page-fault error code that describes the access. The rights register is loaded from its write port. A check always sees the register contents as they stood in the cycle the check was presented.

Top module: `pg_rights_check`

## Requirements
- R1: A check presented with `chk_valid` in cycle t produces `res_valid`=1 in cycle t+1, with exactly one of `allow` and `fault` set. In a cycle after no check, `res_valid`, `allow`, `fault` and `err_code` are all 0.
- R2: Synchronous active-high `rst` clears the rights register and all outputs to zero.
- R3: An entry whose bit 0 is clear faults. Its error code has bit 0 clear, bit 3 clear and bit 5 clear.
- R4: On a present entry, a write faults when entry bit 1 is clear. An access made in user mode (`user_mode`=1) faults when entry bit 2 is clear.
- R5: An instruction fetch (`acc_kind`=2) from a present entry with bit 63 set faults.
- R6: A data access (`acc_kind` 0=read or 1=write) to a present entry with bit 2 set faults and sets error bit 5 when rights bit 2k is set. Here k is entry bits 62:59.
- R7: A write to such a page also faults, with error bit 5, when rights bit 2k+1 is set. A read is not blocked by that bit. Fetches and pages with entry bit 2 clear are not subject to key checks.
- R8: A present entry presented with `rsvd_flag`=1 faults, with error bits 0 and 3 set.
- R9: On a fault, the error code bits are set as follows: bit 0 = entry bit 0, bit 1 = access is a write, bit 2 = `user_mode`, bit 4 = access is a fetch. Bits 31:6 are always 0. When the access is allowed, the code is 0.
- R10: A rights-register write takes effect from the next cycle. A check in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkr_wr_en | input | 1 | Rights register write strobe |
| pkr_wr_data | input | 32 | New rights register value |
| chk_valid | input | 1 | A check is presented this cycle |
| leaf_entry | input | 64 | Leaf translation entry |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| user_mode | input | 1 | Access made at user privilege |
| rsvd_flag | input | 1 | Walker found reserved bits set |
| res_valid | output | 1 | Result valid |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access denied |
| err_code | output | 32 | Page-fault error code (0 when allowed) |

## Verification
A check and a rights-register update can arrive in the same cycle. The bench drives exactly that: it sets a key's access-disable bit in the same cycle as a user read through that key, and expects the read to be allowed. It then repeats the same read in the next cycle and expects a fault with the key bit set in the error code. A behavioural model applies register writes only after it has evaluated that cycle's check. The model is compared on every clock, across directed cases and a long random stream in which writes and checks often coincide.

// File: rtl/pgr_pkg.sv
`timescale 1ns/1ps
package pgr_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // individual denial causes found by the rule evaluator
  typedef struct packed {
    logic not_present;
    logic rsvd;
    logic no_write;
    logic no_user;
    logic no_exec;
    logic key_block;
  } viol_t;

  localparam int ERR_PRESENT = 0;
  localparam int ERR_WRITE   = 1;
  localparam int ERR_USER    = 2;
  localparam int ERR_RSVD    = 3;
  localparam int ERR_FETCH   = 4;
  localparam int ERR_KEY     = 5;
endpackage

// File: rtl/pkr_regfile.sv
`timescale 1ns/1ps
module pkr_regfile #(
  parameter int KEY_BITS = 4,
  localparam int NUM_KEYS = 1 << KEY_BITS,
  localparam int PKR_W = 2 * NUM_KEYS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [PKR_W-1:0]    wr_data,
  input  logic [KEY_BITS-1:0] key,
  output logic                acc_dis,
  output logic                wr_dis,
  output logic [PKR_W-1:0]    pkr_q
);
  logic [NUM_KEYS-1:0] ad_vec;
  logic [NUM_KEYS-1:0] wd_vec;

  always_ff @(posedge clk) begin
    if (rst)        pkr_q <= '0;
    else if (wr_en) pkr_q <= wr_data;
  end

  // split the packed register into per-key slot vectors
  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_slot
    assign ad_vec[i] = pkr_q[2*i];
    assign wd_vec[i] = pkr_q[2*i+1];
  end

  assign acc_dis = ad_vec[key];
  assign wr_dis  = wd_vec[key];
endmodule

// File: rtl/perm_eval.sv
`timescale 1ns/1ps
module perm_eval import pgr_pkg::*; (
  input  logic      present,
  input  logic      grant_wr,
  input  logic      grant_usr,
  input  logic      nx,
  input  logic [1:0] kind,
  input  logic      user_mode,
  input  logic      rsvd_flag,
  input  logic      key_ad,
  input  logic      key_wd,
  output viol_t     viol
);
  acc_kind_e k;
  logic is_wr, is_fetch, is_data;

  always_comb begin
    k        = acc_kind_e'(kind);
    is_wr    = (k == ACC_WRITE);
    is_fetch = (k == ACC_FETCH);
    is_data  = !is_fetch;
    viol             = '0;
    viol.not_present = !present;
    viol.rsvd        = present && rsvd_flag;
    viol.no_write    = present && is_wr && !grant_wr;
    viol.no_user     = present && user_mode && !grant_usr;
    viol.no_exec     = present && is_fetch && nx;
    viol.key_block   = present && grant_usr && is_data &&
                       (key_ad || (is_wr && key_wd));
  end
endmodule

// File: rtl/err_build.sv
`timescale 1ns/1ps
module err_build import pgr_pkg::*; #(
  parameter int ERR_W = 32
) (
  input  viol_t          viol,
  input  logic [1:0]     kind,
  input  logic           user_mode,
  output logic           deny,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    deny = |viol;
    code = '0;
    if (deny) begin
      code[ERR_PRESENT] = !viol.not_present;
      code[ERR_WRITE]   = (acc_kind_e'(kind) == ACC_WRITE);
      code[ERR_USER]    = user_mode;
      code[ERR_RSVD]    = viol.rsvd;
      code[ERR_FETCH]   = (acc_kind_e'(kind) == ACC_FETCH);
      code[ERR_KEY]     = viol.key_block;
    end
  end
endmodule

// File: rtl/pg_rights_check.sv
`timescale 1ns/1ps
module pg_rights_check import pgr_pkg::*; #(
  parameter int ENTRY_W  = 64,
  parameter int KEY_BITS = 4,
  parameter int KEY_LSB  = 59,
  parameter int NX_BIT   = 63,
  parameter int ERR_W    = 32,
  localparam int PKR_W   = 2 * (1 << KEY_BITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkr_wr_en,
  input  logic [PKR_W-1:0]   pkr_wr_data,
  input  logic               chk_valid,
  input  logic [ENTRY_W-1:0] leaf_entry,
  input  logic [1:0]         acc_kind,
  input  logic               user_mode,
  input  logic               rsvd_flag,
  output logic               res_valid,
  output logic               allow,
  output logic               fault,
  output logic [ERR_W-1:0]   err_code
);
  localparam int KEY_MSB = KEY_LSB + KEY_BITS - 1;

  logic [KEY_BITS-1:0] key;
  logic [PKR_W-1:0]    pkr_q;
  logic                key_ad, key_wd, deny;
  logic [ERR_W-1:0]    code_c;
  viol_t               viol;
  logic                unused_entry_bits;

  assign key = leaf_entry[KEY_MSB:KEY_LSB];
  assign unused_entry_bits = ^leaf_entry[KEY_LSB-1:3];

  pkr_regfile #(.KEY_BITS(KEY_BITS)) u_pkr (
    .clk(clk), .rst(rst), .wr_en(pkr_wr_en), .wr_data(pkr_wr_data),
    .key(key), .acc_dis(key_ad), .wr_dis(key_wd), .pkr_q(pkr_q)
  );

  perm_eval u_eval (
    .present(leaf_entry[0]), .grant_wr(leaf_entry[1]),
    .grant_usr(leaf_entry[2]), .nx(leaf_entry[NX_BIT]),
    .kind(acc_kind), .user_mode(user_mode), .rsvd_flag(rsvd_flag),
    .key_ad(key_ad), .key_wd(key_wd), .viol(viol)
  );

  err_build #(.ERR_W(ERR_W)) u_err (
    .viol(viol), .kind(acc_kind), .user_mode(user_mode),
    .deny(deny), .code(code_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      allow     <= 1'b0;
      fault     <= 1'b0;
      err_code  <= '0;
    end else begin
      res_valid <= chk_valid;
      allow     <= chk_valid && !deny;
      fault     <= chk_valid && deny;
      err_code  <= chk_valid ? code_c : '0;
    end
  end
endmodule

// File: rtl/pgr_checker.sv
`timescale 1ns/1ps
module pgr_checker (
  input logic        clk,
  input logic        rst,
  input logic        pkr_wr_en,
  input logic [31:0] pkr_wr_data,
  input logic [31:0] pkr_q,
  input logic        chk_valid,
  input logic [63:0] leaf_entry,
  input logic [1:0]  acc_kind,
  input logic        rsvd_flag,
  input logic        res_valid,
  input logic        allow,
  input logic        fault,
  input logic [31:0] err_code
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid && (allow != fault));
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !allow && !fault && err_code == 32'd0);
  assert_nonpresent_R3: assert property (@(posedge clk) disable iff (rst)
    chk_valid && !leaf_entry[0] |=> fault && !err_code[0] && !err_code[3] && !err_code[5]);
  assert_noexec_R5: assert property (@(posedge clk) disable iff (rst)
    chk_valid && leaf_entry[0] && leaf_entry[63] && acc_kind == 2'd2 |=> fault && err_code[4]);
  assert_rsvd_R8: assert property (@(posedge clk) disable iff (rst)
    chk_valid && leaf_entry[0] && rsvd_flag |=> fault && err_code[0] && err_code[3]);
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    err_code[31:6] == 26'd0 && (allow -> err_code == 32'd0));
  assert_pkr_load_R10: assert property (@(posedge clk) disable iff (rst)
    pkr_wr_en |=> pkr_q == $past(pkr_wr_data));
endmodule

bind pg_rights_check pgr_checker u_pgr_checker (
  .clk(clk), .rst(rst), .pkr_wr_en(pkr_wr_en), .pkr_wr_data(pkr_wr_data),
  .pkr_q(pkr_q), .chk_valid(chk_valid), .leaf_entry(leaf_entry),
  .acc_kind(acc_kind), .rsvd_flag(rsvd_flag), .res_valid(res_valid),
  .allow(allow), .fault(fault), .err_code(err_code)
);

// File: tb/test_pg_rights_check.sv
`timescale 1ns/1ps
module test_pg_rights_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkr_wr_en = 1'b0;
  logic [31:0] pkr_wr_data = '0;
  logic        chk_valid = 1'b0;
  logic [63:0] leaf_entry = '0;
  logic [1:0]  acc_kind = '0;
  logic        user_mode = 1'b0;
  logic        rsvd_flag = 1'b0;
  logic        res_valid, allow, fault;
  logic [31:0] err_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] mdl_pkr = '0;

  always #2.5 clk = ~clk;

  pg_rights_check i_pg_rights_check (
    .clk(clk), .rst(rst), .pkr_wr_en(pkr_wr_en), .pkr_wr_data(pkr_wr_data),
    .chk_valid(chk_valid), .leaf_entry(leaf_entry), .acc_kind(acc_kind),
    .user_mode(user_mode), .rsvd_flag(rsvd_flag), .res_valid(res_valid),
    .allow(allow), .fault(fault), .err_code(err_code)
  );

  function automatic logic [63:0] mk(bit p, bit w, bit u, int k, bit x);
    logic [63:0] e = '0;
    e[0] = p; e[1] = w; e[2] = u; e[62:59] = k[3:0]; e[63] = x;
    return e;
  endfunction

  // behavioural reference: returns {res_valid, allow, fault, err_code}
  function automatic logic [34:0] model(bit v, logic [63:0] e, logic [1:0] kd,
                                         bit um, bit rv, logic [31:0] pk);
    bit f = 0;
    logic [31:0] ec = '0;
    bit wr = (kd == 2'd1);
    bit fe = (kd == 2'd2);
    int k = int'(e[62:59]);
    if (!v) return '0;
    if (e[0] == 1'b0) f = 1;
    else begin
      if (rv) begin f = 1; ec[3] = 1; end
      if (wr && !e[1]) f = 1;
      if (um && !e[2]) f = 1;
      if (fe && e[63]) f = 1;
      if (e[2] && !fe) begin
        if (pk[2*k]) begin f = 1; ec[5] = 1; end
        if (wr && pk[2*k+1]) begin f = 1; ec[5] = 1; end
      end
    end
    if (f) begin
      ec[0] = e[0]; ec[1] = wr; ec[2] = um; ec[4] = fe;
    end else ec = '0;
    return {1'b1, !f, f, ec};
  endfunction

  task automatic compare(logic [34:0] exp, string req);
    checks++;
    if ({res_valid, allow, fault, err_code} !== exp) begin
      fails++;
      $display("FAIL %s: got v=%b a=%b f=%b ec=%h, expected v=%b a=%b f=%b ec=%h",
               req, res_valid, allow, fault, err_code,
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic cyc(bit v, logic [63:0] e, logic [1:0] kd, bit um, bit rv,
                     bit we, logic [31:0] wd, string req);
    logic [34:0] exp;
    @(negedge clk);
    chk_valid = v; leaf_entry = e; acc_kind = kd; user_mode = um;
    rsvd_flag = rv; pkr_wr_en = we; pkr_wr_data = wd;
    exp = model(v, e, kd, um, rv, mdl_pkr);   // check sees old register
    if (we) mdl_pkr = wd;
    @(posedge clk);
    #1;
    compare(exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({res_valid, allow, fault, err_code} !== 35'd0) begin
      fails++;
      $display("FAIL R2: got outputs %h, expected 0", {res_valid, allow, fault, err_code});
    end
    rst = 1'b0;
    // R2: register cleared -> user read through key 9 allowed
    cyc(1, mk(1,1,1,9,0), 2'd0, 1, 0, 0, 0, "R2");
    cyc(0, '0, 2'd0, 0, 0, 0, 0, "R1 idle");
    cyc(1, mk(1,0,0,0,0), 2'd0, 0, 0, 0, 0, "R1 supervisor read");
    cyc(1, mk(1,0,1,0,0), 2'd1, 1, 0, 0, 0, "R4 write to read-only");
    cyc(1, mk(1,1,0,0,0), 2'd0, 1, 0, 0, 0, "R4 user on supervisor page");
    cyc(1, mk(0,1,1,0,0), 2'd2, 1, 0, 0, 0, "R3 non-present fetch");
    cyc(1, mk(0,0,0,0,0), 2'd1, 0, 1, 0, 0, "R3 non-present with rsvd");
    cyc(1, mk(1,1,1,0,1), 2'd2, 0, 0, 0, 0, "R5 fetch no-exec");
    cyc(1, mk(1,1,1,0,1), 2'd0, 0, 0, 0, 0, "R5 read no-exec allowed");
    cyc(1, mk(1,1,1,0,0), 2'd0, 0, 1, 0, 0, "R8 reserved flag");
    // R10: write AD for key 3 in the same cycle as a check on key 3
    cyc(1, mk(1,1,1,3,0), 2'd0, 1, 0, 1, 32'h0000_0040, "R10 same-cycle old value");
    cyc(1, mk(1,1,1,3,0), 2'd0, 1, 0, 0, 0, "R6 access-disable read");
    cyc(1, mk(1,1,1,3,0), 2'd1, 0, 0, 0, 0, "R6 access-disable write");
    cyc(1, mk(1,1,1,3,0), 2'd2, 1, 0, 0, 0, "R7 fetch ignores key");
    cyc(1, mk(1,1,0,3,0), 2'd0, 0, 0, 0, 0, "R7 supervisor page ignores key");
    cyc(1, mk(1,1,1,5,0), 2'd0, 1, 0, 1, 32'h0000_0800, "R10 write WD key5");
    cyc(1, mk(1,1,1,5,0), 2'd0, 1, 0, 0, 0, "R7 write-disable read allowed");
    cyc(1, mk(1,1,1,5,0), 2'd1, 1, 0, 0, 0, "R7 write-disable write");
    cyc(1, mk(1,1,1,15,0), 2'd1, 1, 0, 1, 32'h8000_0000, "R10 write WD key15");
    cyc(1, mk(1,1,1,15,0), 2'd1, 1, 0, 0, 0, "R7 top key write");
    for (int i = 0; i < 600; i++) begin
      logic [63:0] e = {$urandom, $urandom};
      if (($urandom % 8) != 0) e[0] = 1'b1;
      cyc(($urandom % 5) != 0, e, 2'($urandom % 4), 1'($urandom), ($urandom % 6) == 0,
          ($urandom % 3) == 0, $urandom, "R9 random");
    end
    rst = 1'b1;
    @(posedge clk); #1;
    checks++;
    if ({res_valid, allow, fault, err_code} !== 35'd0) begin
      fails++;
      $display("FAIL R2: got outputs %h after reset, expected 0", {res_valid, allow, fault, err_code});
    end
    mdl_pkr = '0;
    @(negedge clk); rst = 1'b0;
    cyc(1, mk(1,1,1,15,0), 2'd1, 1, 0, 0, 0, "R2 register cleared");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule